// File: doc/BRIEF.md
# Timer Compare Pulse Channel

This block is one output-compare channel that watches a free-running 31-bit timestamp counter and emits a one-cycle high pulse each time the counter equals a programmed target. A typical use is a pulse-per-second output. Software loads a target, then keeps loading the one after it, so that the pulse train continues without a gap. Each match sets a sticky event flag. Software clears the flag by writing a one to it. An interrupt is raised while the flag is set and interrupts are enabled.

The compare storage holds two entries: an active target and one queued target. A small state machine tracks how many entries are in use. In `CS_IDLE` there is no target. In `CS_ARMED` only the active target is valid. In `CS_QUEUED` both entries are valid.

The machine moves through the following named transitions:
- `T_LOAD`, from `CS_IDLE` to `CS_ARMED`: a compare write loads the active slot.
- `T_ENQ`, from `CS_ARMED` to `CS_QUEUED`: a write fills the queue.
- `T_REPLACE`, from `CS_QUEUED` to itself: a write overwrites the queued value.
- `T_PROMOTE`, from `CS_QUEUED` to `CS_ARMED`: on a match, the queued value moves into the active slot.
- `T_DRAIN`, from `CS_ARMED` to `CS_IDLE`: a match occurs with the queue empty.
- `T_DROP`, from `CS_ARMED` or `CS_QUEUED` to `CS_IDLE`: the counter wraps while operation across the wrap is disabled.

A write in the same cycle as `T_PROMOTE`, `T_DRAIN` or `T_DROP` takes the first empty slot that the transition leaves.

Top module: `tcmp_pulse_chan`

## Requirements
- R1: After reset, the following outputs are all 0: `pulse_o`, `flag_o`, `irq_o`, `mode_o`, `dma_en_o`, `busy_o` and `next_full_o`.
- R2: The channel matches when the state is not `CS_IDLE`, `mode_o` equals 1 (high-pulse mode), and `tmr_cnt` equals the active target in all 31 bits. This includes the value 0x7FFFFFFF. On a match, `pulse_o` is high for exactly the one cycle after the matching edge.
- R3: With `mode_o` equal to 0 (disabled), 2 or 3 (reserved), a counter equal to the target produces no pulse and no flag. The target stays armed until the mode becomes 1.
- R4: A match sets `flag_o`. `flag_o` stays set until `flag_clr` is pulsed. If a match and `flag_clr` occur in the same cycle, the flag remains set.
- R5: `irq_o` is high exactly when both `flag_o` and the interrupt enable are set.
- R6: A compare write while in `CS_ARMED` is queued (`next_full_o`=1). On the next match, the queued value becomes the active target, so the following pulse occurs at the queued value.
- R7: A match with an empty queue returns the channel to `CS_IDLE` (`busy_o`=0). Later equality with the old target gives no pulse until a new value is written.
- R8: A compare write while in `CS_QUEUED` replaces the queued value and leaves the active target unchanged.
- R9: A counter wrap is any cycle in which `tmr_cnt` is lower than its value on the previous cycle. With `wrap_cmp_en`=0, a wrap discards all armed targets. With `wrap_cmp_en`=1, the targets survive the wrap and still match afterwards.
- R10: The DMA request enable bit is stored and reflected on `dma_en_o`. It has no effect on the pulse, the flag or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt | input | 31 | Timestamp counter value |
| wrap_cmp_en | input | 1 | Global enable for compare operation across counter wrap |
| ctl_we | input | 1 | Write strobe for mode, interrupt enable and DMA enable |
| ctl_mode | input | 2 | Mode value: 0 disabled, 1 high pulse, 2 and 3 reserved |
| ctl_irq_en | input | 1 | Interrupt enable value |
| ctl_dma_en | input | 1 | DMA request enable value |
| flag_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 31 | Compare value |
| pulse_o | output | 1 | One-cycle compare pulse |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Event flag |
| mode_o | output | 2 | Current mode readback |
| dma_en_o | output | 1 | DMA request enable readback |
| busy_o | output | 1 | Active target valid |
| next_full_o | output | 1 | Queued target valid |

## Verification
The hardest situation to reach from the ports is a write that lands in the same cycle as a match, or in the same cycle as a flag clear. Either case requires the counter input, the strobe and the armed state to line up on a single edge.

The bench drives the counter directly, cycle by cycle, instead of letting it free-run. This lets it place the counter at the target value in exactly the cycle in which it asserts `flag_clr`. The bench also reaches the wrap-drop path by stepping the counter backwards while targets are armed.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_ARMED  = 2'd1,
        CS_QUEUED = 2'd2
    } cmp_state_e;

    localparam int unsigned MODE_PULSE_CODE = 1;

endpackage

// File: rtl/tcmp_wrap_det.sv
module tcmp_wrap_det #(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    output logic          wrapped
);

    logic [CW-1:0] prev_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_cnt <= '0;
        else        prev_cnt <= cnt;
    end

    assign wrapped = (cnt < prev_cnt);

endmodule

// File: rtl/tcmp_ctl_regs.sv
module tcmp_ctl_regs #(
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [MW-1:0] ctl_mode,
    input  logic          ctl_irq_en,
    input  logic          ctl_dma_en,
    input  logic          flag_clr,
    input  logic          hit,
    output logic [MW-1:0] mode_q,
    output logic          dma_en_q,
    output logic          flag_q,
    output logic          irq
);

    logic irq_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            irq_en_q <= 1'b0;
            dma_en_q <= 1'b0;
        end else if (ctl_we) begin
            mode_q   <= ctl_mode;
            irq_en_q <= ctl_irq_en;
            dma_en_q <= ctl_dma_en;
        end
    end

    // Set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & irq_en_q;

    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag_q);

endmodule

// File: rtl/tcmp_cmp_seq.sv
module tcmp_cmp_seq
    import tcmp_pkg::*;
#(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          mode_pulse,
    input  logic          wrapped,
    input  logic          wrap_cmp_en,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic          hit,
    output logic          pulse,
    output logic          busy,
    output logic          next_full
);

    cmp_state_e    st, st_n;
    logic [CW-1:0] act_q, act_n;
    logic [CW-1:0] nxt_q, nxt_n;
    logic          drop;

    assign hit  = (st != CS_IDLE) && mode_pulse && (cnt == act_q);
    assign drop = (st != CS_IDLE) && wrapped && !wrap_cmp_en;

    always_comb begin
        st_n  = st;
        act_n = act_q;
        nxt_n = nxt_q;
        unique case (st)
            CS_IDLE: begin
                if (wr) begin                 // T_LOAD
                    act_n = wdata;
                    st_n  = CS_ARMED;
                end
            end
            CS_ARMED: begin
                if (hit || drop) begin        // T_DRAIN / T_DROP
                    if (wr) act_n = wdata;
                    else    st_n  = CS_IDLE;
                end else if (wr) begin        // T_ENQ
                    nxt_n = wdata;
                    st_n  = CS_QUEUED;
                end
            end
            CS_QUEUED: begin
                if (hit) begin                // T_PROMOTE
                    act_n = nxt_q;
                    st_n  = CS_ARMED;
                    if (wr) begin
                        nxt_n = wdata;
                        st_n  = CS_QUEUED;
                    end
                end else if (drop) begin      // T_DROP
                    if (wr) begin
                        act_n = wdata;
                        st_n  = CS_ARMED;
                    end else begin
                        st_n  = CS_IDLE;
                    end
                end else if (wr) begin        // T_REPLACE
                    nxt_n = wdata;
                end
            end
            default: st_n = CS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= CS_IDLE;
            act_q <= '0;
            nxt_q <= '0;
        end else begin
            st    <= st_n;
            act_q <= act_n;
            nxt_q <= nxt_n;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse     <= 1'b0;
            busy      <= 1'b0;
            next_full <= 1'b0;
        end else begin
            pulse     <= hit;
            busy      <= (st_n != CS_IDLE);
            next_full <= (st_n == CS_QUEUED);
        end
    end

    a_r2_pulse_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pulse);

    a_r7_drain_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_ARMED && hit && !wr) |=> (st == CS_IDLE));

    a_r6_promote: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_QUEUED && hit && !wr) |=> (st == CS_ARMED && act_q == $past(nxt_q)));

    a_r8_replace_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_QUEUED && !hit && !drop && wr) |=> (st == CS_QUEUED && $stable(act_q)));

    a_r9_wrap_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !hit && !wr) |=> (st == CS_IDLE));

endmodule

// File: rtl/tcmp_pulse_chan.sv
module tcmp_pulse_chan
    import tcmp_pkg::*;
#(
    parameter int CW = 31,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tmr_cnt,
    input  logic          wrap_cmp_en,
    input  logic          ctl_we,
    input  logic [MW-1:0] ctl_mode,
    input  logic          ctl_irq_en,
    input  logic          ctl_dma_en,
    input  logic          flag_clr,
    input  logic          cmp_we,
    input  logic [CW-1:0] cmp_wdata,
    output logic          pulse_o,
    output logic          irq_o,
    output logic          flag_o,
    output logic [MW-1:0] mode_o,
    output logic          dma_en_o,
    output logic          busy_o,
    output logic          next_full_o
);

    localparam logic [MW-1:0] MODE_PULSE = MW'(MODE_PULSE_CODE);

    logic hit;
    logic wrapped;
    logic mode_pulse;

    assign mode_pulse = (mode_o == MODE_PULSE);

    tcmp_wrap_det #(.CW(CW)) u_wrap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (tmr_cnt),
        .wrapped (wrapped)
    );

    tcmp_ctl_regs #(.MW(MW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_mode   (ctl_mode),
        .ctl_irq_en (ctl_irq_en),
        .ctl_dma_en (ctl_dma_en),
        .flag_clr   (flag_clr),
        .hit        (hit),
        .mode_q     (mode_o),
        .dma_en_q   (dma_en_o),
        .flag_q     (flag_o),
        .irq        (irq_o)
    );

    tcmp_cmp_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt         (tmr_cnt),
        .mode_pulse  (mode_pulse),
        .wrapped     (wrapped),
        .wrap_cmp_en (wrap_cmp_en),
        .wr          (cmp_we),
        .wdata       (cmp_wdata),
        .hit         (hit),
        .pulse       (pulse_o),
        .busy        (busy_o),
        .next_full   (next_full_o)
    );

    a_r3_no_pulse_unless_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_PULSE) |=> !pulse_o);

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

endmodule

// File: tb/test_tcmp_pulse_chan.sv
module test_tcmp_pulse_chan;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [30:0] tmr_cnt;
    logic        wrap_cmp_en;
    logic        ctl_we;
    logic [1:0]  ctl_mode;
    logic        ctl_irq_en;
    logic        ctl_dma_en;
    logic        flag_clr;
    logic        cmp_we;
    logic [30:0] cmp_wdata;
    logic        pulse_o, irq_o, flag_o, dma_en_o, busy_o, next_full_o;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    tcmp_pulse_chan i_tcmp_pulse_chan (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .wrap_cmp_en(wrap_cmp_en),
        .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_irq_en(ctl_irq_en),
        .ctl_dma_en(ctl_dma_en), .flag_clr(flag_clr), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .pulse_o(pulse_o), .irq_o(irq_o), .flag_o(flag_o),
        .mode_o(mode_o), .dma_en_o(dma_en_o), .busy_o(busy_o),
        .next_full_o(next_full_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: inputs set now (after a falling edge), outputs sampled at next falling edge.
    task automatic tick(input logic [30:0] c);
        tmr_cnt = c;
        @(negedge clk);
        ctl_we   = 1'b0;
        cmp_we   = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [30:0] v, input logic [30:0] c);
        cmp_we    = 1'b1;
        cmp_wdata = v;
        tick(c);
    endtask

    task automatic wr_ctl(input logic [1:0] m, input logic ie, input logic de, input logic [30:0] c);
        ctl_we     = 1'b1;
        ctl_mode   = m;
        ctl_irq_en = ie;
        ctl_dma_en = de;
        tick(c);
    endtask

    task automatic clr_flag(input logic [30:0] c);
        flag_clr = 1'b1;
        tick(c);
    endtask

    task automatic t_reset;
        chk("R1 pulse", {31'd0, pulse_o}, 0);
        chk("R1 flag", {31'd0, flag_o}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 mode", {30'd0, mode_o}, 0);
        chk("R1 dma", {31'd0, dma_en_o}, 0);
        chk("R1 busy", {30'd0, busy_o, next_full_o}, 0);
    endtask

    task automatic t_basic;
        wr_ctl(2'd1, 1'b0, 1'b0, 31'd1);
        wr_cmp(31'd10, 31'd5);
        chk("R2 armed", {31'd0, busy_o}, 1);
        tick(31'd8);
        chk("R2 no early pulse", {31'd0, pulse_o}, 0);
        tick(31'd10);
        chk("R2 pulse at match", {31'd0, pulse_o}, 1);
        chk("R4 flag set", {31'd0, flag_o}, 1);
        chk("R5 irq off when ie=0", {31'd0, irq_o}, 0);
        tick(31'd11);
        chk("R2 pulse one cycle", {31'd0, pulse_o}, 0);
        chk("R7 idle after drain", {31'd0, busy_o}, 0);
        chk("R4 flag sticky", {31'd0, flag_o}, 1);
        tick(31'd12);
        tick(31'd10);
        chk("R7 no pulse when idle", {31'd0, pulse_o}, 0);
        clr_flag(31'd13);
        chk("R4 flag cleared", {31'd0, flag_o}, 0);
    endtask

    task automatic t_mode_off;
        wr_ctl(2'd0, 1'b0, 1'b0, 31'd14);
        wr_cmp(31'd20, 31'd15);
        tick(31'd20);
        chk("R3 mode 0 no pulse", {31'd0, pulse_o}, 0);
        chk("R3 mode 0 no flag", {31'd0, flag_o}, 0);
        wr_ctl(2'd2, 1'b0, 1'b0, 31'd0);
        tick(31'd20);
        chk("R3 mode 2 no pulse", {31'd0, pulse_o}, 0);
        chk("R3 target kept", {31'd0, busy_o}, 1);
        wr_ctl(2'd1, 1'b0, 1'b0, 31'd0);
        tick(31'd20);
        chk("R3 pulse after mode 1", {31'd0, pulse_o}, 1);
        clr_flag(31'd21);
    endtask

    task automatic t_queue;
        wr_ctl(2'd1, 1'b1, 1'b0, 31'd22);
        wr_cmp(31'd100, 31'd50);
        wr_cmp(31'd200, 31'd51);
        chk("R6 queue full", {31'd0, next_full_o}, 1);
        tick(31'd100);
        chk("R6 first pulse", {31'd0, pulse_o}, 1);
        chk("R6 queue promoted", {30'd0, busy_o, next_full_o}, 2'b10);
        chk("R5 irq with ie=1", {31'd0, irq_o}, 1);
        tick(31'd150);
        chk("R6 quiet between", {31'd0, pulse_o}, 0);
        tick(31'd200);
        chk("R6 pulse at queued value", {31'd0, pulse_o}, 1);
        tick(31'd201);
        chk("R7 idle after second", {31'd0, busy_o}, 0);
        clr_flag(31'd202);
        chk("R5 irq drops with flag", {31'd0, irq_o}, 0);
    endtask

    task automatic t_replace;
        wr_cmp(31'd300, 31'd290);
        wr_cmp(31'd400, 31'd291);
        wr_cmp(31'd500, 31'd292);
        tick(31'd300);
        chk("R8 active kept", {31'd0, pulse_o}, 1);
        tick(31'd400);
        chk("R8 replaced value ignored", {31'd0, pulse_o}, 0);
        tick(31'd500);
        chk("R8 new queued value fires", {31'd0, pulse_o}, 1);
    endtask

    task automatic t_set_clr_race;
        wr_cmp(31'd600, 31'd550);
        flag_clr = 1'b1;
        tick(31'd600);
        chk("R4 set wins over clear", {31'd0, flag_o}, 1);
        clr_flag(31'd601);
        chk("R4 clear after race", {31'd0, flag_o}, 0);
    endtask

    task automatic t_wrap;
        wr_cmp(31'h7FFFFFFF, 31'd700);
        tick(31'h7FFFFFFF);
        chk("R2 match at max", {31'd0, pulse_o}, 1);
        wrap_cmp_en = 1'b0;
        tick(31'd1);
        wr_cmp(31'd5, 31'd2);
        tick(31'd3);
        tick(31'd0);
        chk("R9 wrap drops target", {31'd0, busy_o}, 0);
        tick(31'd5);
        chk("R9 no pulse after drop", {31'd0, pulse_o}, 0);
        wrap_cmp_en = 1'b1;
        wr_cmp(31'd5, 31'd1);
        tick(31'd0);
        chk("R9 target survives wrap", {31'd0, busy_o}, 1);
        tick(31'd5);
        chk("R9 pulse after wrap", {31'd0, pulse_o}, 1);
        clr_flag(31'd6);
    endtask

    task automatic t_dma;
        wr_ctl(2'd1, 1'b1, 1'b1, 31'd7);
        chk("R10 dma readback", {31'd0, dma_en_o}, 1);
        wr_cmp(31'd10, 31'd8);
        tick(31'd10);
        chk("R10 pulse with dma", {31'd0, pulse_o}, 1);
        chk("R10 irq with dma", {31'd0, irq_o}, 1);
        clr_flag(31'd11);
        chk("R10 flag clear with dma", {31'd0, flag_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        tmr_cnt     = '0;
        wrap_cmp_en = 1'b1;
        ctl_we      = 1'b0;
        ctl_mode    = '0;
        ctl_irq_en  = 1'b0;
        ctl_dma_en  = 1'b0;
        flag_clr    = 1'b0;
        cmp_we      = 1'b0;
        cmp_wdata   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mode_off();
        t_queue();
        t_replace();
        t_set_clr_race();
        t_wrap();
        t_dma();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule